// File: doc/BRIEF.md
# Chained Wide Multiply-Accumulate Unit

This unit holds three 64-bit multiplier words and three hidden 64-bit carry words. Together they let a host chain unsigned multiplications across several machine words, which is the inner loop of big-number arithmetic. A command port accepts one operation at a time. Every command carries two 64-bit operands, `a` and `b`, and returns one 64-bit result through a valid/ready handshake.

The two multiply-add operations feed the upper words of their sum back into the carry words. The next multiply-add therefore picks up where the last one stopped. Loading any multiplier word starts a fresh chain. The multiplier works iteratively and forms one 64x64 partial product per cycle into a wide accumulator. The single-word operations take one multiply cycle and the triple-word operation takes three.

Operation codes on `cmd_op_i`:

| Code | Operation |
|------|-----------|
| 0 | write a multiplier word |
| 1 | write a carry word |
| 2 | single-word multiply-add |
| 3 | triple-word multiply-add |
| 4 | multiply-add-and-reload |

`cmd_sel_i` picks the word index, from 0 to 2.

Top module: `wmac_unit`

## Requirements
- R1: After reset, all three multiplier words and all three carry words are zero. A single-word multiply-add issued first returns `b`.
- R2: Op code 0 with index n loads multiplier word n from `a` and clears all three carry words.
- R3: Op code 1 with index n loads carry word n from `a` and changes no other word.
- R4: Op code 2 forms the unsigned sum M0*a + b + C0 of 128 bits. It returns bits 63:0 and stores bits 127:64 in C0. `res_valid_o` rises on the second clock edge after acceptance.
- R5: Op code 3 forms the unsigned 256-bit sum {M2,M1,M0}*a + b + {C2,C1,C0}, with every carry rippling up to bit 255. It returns bits 63:0 and stores bits 127:64, 191:128 and 255:192 in C0, C1 and C2. `res_valid_o` rises on the fourth clock edge after acceptance.
- R6: Op code 4 returns the low 64 bits of M0*a + b + C0. It writes that value into M0 and clears all three carry words. The result arrives with the same latency as R4.
- R7: All operands are treated as unsigned, so all-ones words produce full-width products.
- R8: Op codes 0 and 1 complete on the first clock edge after acceptance, with a result of zero.
- R9: While a result is valid and not yet taken, `cmd_ready_o` stays low, no command is accepted, and `res_data_o` holds its value.
- R10: Op codes 5 to 7 change no state. Write commands with an index of 3 also change no state. Both complete as R8 describes, with a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Unit can take a command |
| cmd_op_i | input | 3 | Operation code |
| cmd_sel_i | input | 2 | Word index for write commands |
| cmd_a_i | input | 64 | Operand a |
| cmd_b_i | input | 64 | Operand b |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Result taken |
| res_data_o | output | 64 | Result word |

## Verification
Two things can coincide in one cycle: a finished result waiting under back-pressure, and a new command offered at the port. The bench finishes a multiply-add, holds `res_ready_i` low, and drives a carry-word write for several cycles. In every one of those cycles it judges that the result stays unchanged and that `cmd_ready_o` stays low. It then withdraws the write, consumes the result, and reads the carry word back through a zero-operand multiply-add, which shows that the offered write never landed. A second coincidence is checked through the reload operation and the carry clearing that follows it: a later zero-operand read of the carry word must return zero, and a product taken afterwards must use the reloaded multiplier word.

// File: rtl/wmac_pkg.sv
package wmac_pkg;
  typedef enum logic [2:0] {
    OP_SET_MUL  = 3'd0,
    OP_SET_PART = 3'd1,
    OP_MAC1     = 3'd2,
    OP_MAC3     = 3'd3,
    OP_RELOAD   = 3'd4
  } wmac_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CALC,
    ST_DONE
  } wmac_st_e;
endpackage

// File: rtl/wmac_ctrl.sv
module wmac_ctrl
  import wmac_pkg::*;
#(
  parameter int WORDS = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       op_i,
  input  logic             res_ready_i,
  output logic             cmd_ready_o,
  output logic             res_valid_o,
  output logic             accept_o,
  output logic             arith_o,
  output logic             step_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [2:0]       op_q_o
);
  wmac_st_e         st_q;
  logic [IDX_W-1:0] idx_q;
  logic [2:0]       op_q;

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign res_valid_o = (st_q == ST_DONE);
  assign accept_o    = cmd_valid_i && cmd_ready_o;
  assign arith_o     = (op_i == OP_MAC1) || (op_i == OP_MAC3) || (op_i == OP_RELOAD);
  assign step_o      = (st_q == ST_CALC);
  assign last_o      = (op_q == OP_MAC3) ? (idx_q == IDX_W'(WORDS - 1)) : 1'b1;
  assign idx_o       = idx_q;
  assign op_q_o      = op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      op_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept_o) begin
          op_q  <= op_i;
          idx_q <= '0;
          st_q  <= arith_o ? ST_CALC : ST_DONE;
        end
        ST_CALC: begin
          if (last_o) st_q <= ST_DONE;
          else        idx_q <= idx_q + 1'b1;
        end
        ST_DONE: if (res_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !cmd_ready_o);

  // R8
  write_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !arith_o) |=> res_valid_o);
endmodule

// File: rtl/wmac_state.sv
module wmac_state
  import wmac_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORDS  = 3,
  parameter int IDX_W  = 2,
  parameter int ACC_W  = (WORDS + 1) * DATA_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_mul_i,
  input  logic                          wr_part_i,
  input  logic [IDX_W-1:0]              sel_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic                          fin_i,
  input  logic [2:0]                    fin_op_i,
  input  logic [ACC_W-1:0]              acc_i,
  output logic [WORDS-1:0][DATA_W-1:0]  mpl_o,
  output logic [WORDS-1:0][DATA_W-1:0]  part_o
);
  logic sel_ok;
  assign sel_ok = int'(sel_i) < WORDS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mpl_o  <= '0;
      part_o <= '0;
    end else if (wr_mul_i) begin
      if (sel_ok) begin
        mpl_o[sel_i] <= wdata_i;
        part_o       <= '0;
      end
    end else if (wr_part_i) begin
      if (sel_ok) part_o[sel_i] <= wdata_i;
    end else if (fin_i) begin
      unique case (fin_op_i)
        OP_MAC1: part_o[0] <= acc_i[DATA_W +: DATA_W];
        OP_MAC3: for (int k = 0; k < WORDS; k++)
                   part_o[k] <= acc_i[(k+1)*DATA_W +: DATA_W];
        OP_RELOAD: begin
          mpl_o[0] <= acc_i[DATA_W-1:0];
          part_o   <= '0;
        end
        default: ;
      endcase
    end
  end

  // R2
  mul_clears_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mul_i && sel_ok) |=> (part_o == '0));

  // R3
  part_keeps_mul_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_part_i |=> $stable(mpl_o));

  // R10
  bad_sel_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_mul_i || wr_part_i) && !sel_ok) |=> ($stable(mpl_o) && $stable(part_o)));
endmodule

// File: rtl/wmac_datapath.sv
module wmac_datapath #(
  parameter int DATA_W = 64,
  parameter int WORDS  = 3,
  parameter int IDX_W  = 2,
  parameter int ACC_W  = (WORDS + 1) * DATA_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          init_i,
  input  logic                          wide_i,
  input  logic [DATA_W-1:0]             a_i,
  input  logic [DATA_W-1:0]             b_i,
  input  logic [WORDS-1:0][DATA_W-1:0]  part_i,
  input  logic [WORDS-1:0][DATA_W-1:0]  mpl_i,
  input  logic                          step_i,
  input  logic [IDX_W-1:0]              idx_i,
  output logic [ACC_W-1:0]              acc_nxt_o
);
  logic [DATA_W-1:0]   a_q;
  logic [ACC_W-1:0]    acc_q, term, init_val;
  logic [2*DATA_W-1:0] prod;

  always_comb begin
    prod      = {{DATA_W{1'b0}}, mpl_i[idx_i]} * {{DATA_W{1'b0}}, a_q};
    term      = ACC_W'(prod) << (DATA_W * int'(idx_i));
    acc_nxt_o = acc_q + term;
    init_val  = wide_i ? ACC_W'(part_i) + ACC_W'(b_i)
                       : ACC_W'(part_i[0]) + ACC_W'(b_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      a_q   <= '0;
    end else if (init_i) begin
      acc_q <= init_val;
      a_q   <= a_i;
    end else if (step_i) begin
      acc_q <= acc_nxt_o;
    end
  end

  // R5: the widest sum fits the accumulator, so a step never wraps
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (acc_nxt_o >= acc_q));
endmodule

// File: rtl/wmac_unit.sv
module wmac_unit
  import wmac_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORDS  = 3,
  localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [SEL_W-1:0]  cmd_sel_i,
  input  logic [DATA_W-1:0] cmd_a_i,
  input  logic [DATA_W-1:0] cmd_b_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [DATA_W-1:0] res_data_o
);
  localparam int ACC_W = (WORDS + 1) * DATA_W;

  logic                         accept, arith, step, last;
  logic [SEL_W-1:0]             idx;
  logic [2:0]                   op_q;
  logic [ACC_W-1:0]             acc_nxt;
  logic [WORDS-1:0][DATA_W-1:0] mpl, part;
  logic [DATA_W-1:0]            res_q;
  logic                         fin;

  assign fin = step && last;

  wmac_ctrl #(.WORDS(WORDS), .IDX_W(SEL_W)) u_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .op_i(cmd_op_i), .res_ready_i,
    .cmd_ready_o, .res_valid_o, .accept_o(accept), .arith_o(arith),
    .step_o(step), .last_o(last), .idx_o(idx), .op_q_o(op_q)
  );

  wmac_state #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(SEL_W), .ACC_W(ACC_W)) u_state (
    .clk_i, .rst_ni,
    .wr_mul_i (accept && cmd_op_i == OP_SET_MUL),
    .wr_part_i(accept && cmd_op_i == OP_SET_PART),
    .sel_i    (cmd_sel_i),
    .wdata_i  (cmd_a_i),
    .fin_i    (fin),
    .fin_op_i (op_q),
    .acc_i    (acc_nxt),
    .mpl_o    (mpl),
    .part_o   (part)
  );

  wmac_datapath #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(SEL_W), .ACC_W(ACC_W)) u_dp (
    .clk_i, .rst_ni,
    .init_i   (accept && arith),
    .wide_i   (cmd_op_i == OP_MAC3),
    .a_i      (cmd_a_i),
    .b_i      (cmd_b_i),
    .part_i   (part),
    .mpl_i    (mpl),
    .step_i   (step),
    .idx_i    (idx),
    .acc_nxt_o(acc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                res_q <= '0;
    else if (accept && !arith)  res_q <= '0;
    else if (fin)               res_q <= acc_nxt[DATA_W-1:0];
  end
  assign res_data_o = res_q;

  // R9
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)));

  // R8
  write_zero_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !arith) |=> (res_data_o == '0));

  // R6
  reload_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && op_q == OP_RELOAD) |=> (part == '0 && mpl[0] == $past(acc_nxt[DATA_W-1:0])));
endmodule

// File: tb/wmac_unit_bench.sv
module wmac_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_sel = '0;
  logic [63:0] cmd_a = '0, cmd_b = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [63:0] res_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [63:0] m [3];
  logic [63:0] p [3];

  always #5 clk = ~clk;

  wmac_unit u_wmac_unit (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_sel_i(cmd_sel), .cmd_a_i(cmd_a), .cmd_b_i(cmd_b),
    .res_valid_o(res_valid), .res_ready_i(res_ready), .res_data_o(res_data)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sel;
    logic [63:0] a;
    logic [63:0] b;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd0, ONES, 64'd0},
    '{3'd2, 2'd0, ONES, ONES},
    '{3'd2, 2'd0, 64'd0, 64'd0},
    '{3'd0, 2'd1, 64'h1234_5678_9ABC_DEF0, 64'd0},
    '{3'd0, 2'd2, ONES, 64'd0},
    '{3'd1, 2'd0, 64'h1111, 64'd0},
    '{3'd1, 2'd1, ONES, 64'd0},
    '{3'd1, 2'd2, 64'd5, 64'd0},
    '{3'd3, 2'd0, ONES, ONES},
    '{3'd3, 2'd0, 64'd0, 64'd0},
    '{3'd3, 2'd0, 64'd0, 64'd0},
    '{3'd3, 2'd0, 64'd0, 64'd0},
    '{3'd1, 2'd3, 64'hDEAD, 64'd0},
    '{3'd4, 2'd0, 64'd3, 64'd7},
    '{3'd2, 2'd0, 64'd2, 64'd0},
    '{3'd2, 2'd0, 64'd0, 64'd0},
    '{3'd5, 2'd1, ONES, ONES},
    '{3'd1, 2'd0, 64'h42, 64'd0},
    '{3'd2, 2'd0, 64'd0, 64'd0},
    '{3'd3, 2'd0, 64'h8000_0000_0000_0000, 64'd1}
  };

  function automatic string req_of(input logic [2:0] op, input logic [1:0] sel);
    if (op <= 3'd1 && sel == 2'd3) return "R10";
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R10";
    endcase
  endfunction

  function automatic int lat_of(input logic [2:0] op);
    case (op)
      3'd2, 3'd4: return 2;
      3'd3:       return 4;
      default:    return 1;
    endcase
  endfunction

  // reference model, updated per command; returns expected result
  function automatic logic [63:0] model(input logic [2:0] op, input logic [1:0] sel,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [255:0] t;
    case (op)
      3'd0: if (sel < 2'd3) begin m[sel] = a; p[0] = '0; p[1] = '0; p[2] = '0; end
      3'd1: if (sel < 2'd3) p[sel] = a;
      3'd2: begin
        t = {192'd0, m[0]} * {192'd0, a} + {192'd0, b} + {192'd0, p[0]};
        p[0] = t[127:64];
        return t[63:0];
      end
      3'd3: begin
        t = {64'd0, m[2], m[1], m[0]} * {192'd0, a} + {192'd0, b} + {64'd0, p[2], p[1], p[0]};
        p[0] = t[127:64]; p[1] = t[191:128]; p[2] = t[255:192];
        return t[63:0];
      end
      3'd4: begin
        t = {192'd0, m[0]} * {192'd0, a} + {192'd0, b} + {192'd0, p[0]};
        m[0] = t[63:0]; p[0] = '0; p[1] = '0; p[2] = '0;
        return t[63:0];
      end
      default: ;
    endcase
    return 64'd0;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [1:0] sel,
                        input logic [63:0] a, input logic [63:0] b, input bit chk_lat);
    logic [63:0] exp;
    int lat;
    string req;
    req = req_of(op, sel);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_a = a; cmd_b = b;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!res_valid) begin @(negedge clk); lat++; end
    exp = model(op, sel, a, b);
    check(req, "result", res_data, exp);
    if (chk_lat) check(req, "latency", 64'(lat), 64'(lat_of(op)));
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin m[k] = '0; p[k] = '0; end
  endtask

  initial begin
    logic [63:0] held;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1", "ready after reset", 64'(cmd_ready), 64'd1);
    check("R1", "no result after reset", 64'(res_valid), 64'd0);
    rst_ni = 1'b1;

    // R1: first single-word op returns b
    do_cmd(3'd2, 2'd0, 64'hABCD, 64'h1234_0000_0000_5678, 1'b1);
    // R1: triple-word op after reset sees zero carry words
    do_cmd(3'd3, 2'd0, ONES, 64'd0, 1'b1);

    // vector table; R7 through the all-ones operands
    for (int i = 0; i < NV; i++) do_cmd(VEC[i].op, VEC[i].sel, VEC[i].a, VEC[i].b, 1'b1);

    // R9: result pending while a write is offered
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd2; cmd_sel = 2'd0; cmd_a = ONES; cmd_b = 64'd9;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    held = model(3'd2, 2'd0, ONES, 64'd9);
    check("R9", "pending result", res_data, held);
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_sel = 2'd0; cmd_a = 64'h77; cmd_b = 64'd0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R9", "result held", res_data, held);
      check("R9", "ready low while pending", 64'(cmd_ready), 64'd0);
    end
    cmd_valid = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    // R9: offered write must not have landed; carry word 0 read back
    do_cmd(3'd2, 2'd0, 64'd0, 64'd0, 1'b0);

    // R6: carry words cleared after reload, M0 reloaded
    do_cmd(3'd4, 2'd0, 64'd5, 64'd11, 1'b1);
    do_cmd(3'd3, 2'd0, 64'd0, 64'd0, 1'b0);
    do_cmd(3'd2, 2'd0, 64'd1, 64'd0, 1'b0);

    // R1: reset mid-run clears state
    @(negedge clk);
    rst_ni = 1'b0;
    model_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    do_cmd(3'd3, 2'd0, ONES, 64'h55, 1'b0);
    do_cmd(3'd2, 2'd0, 64'd0, 64'd0, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule